// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of an integrating two-phase analog-to-digital converter. Each conversion has two phases. In the first phase the external integrator accumulates the unknown input for a fixed number of clocks, set by an N-bit counter running through every value. In the second phase the integrator input is switched to a negative reference and the same counter measures how many clocks the integrator takes to return to zero. That count, scaled by the fixed first-phase length, is the converted value.

The block takes a start pulse and one comparator bit that stays high while the integrator output is still beyond zero. It drives the switch select and an integrator-clear request, and it latches the final count into a result register. A one-cycle done strobe marks each update. The result register holds its value while the next conversion runs. The whole block runs from a single clock with synchronous enables, and the comparator bit passes through a synchroniser before the block uses it. If the integrator has still not returned to zero after a full counter range, the conversion ends with a saturated result and an overflow flag.

Top module: `dslope_seq`

## Requirements
- R1: While reset is asserted and directly after it, `ref_sel`=0, `integ_clr`=1, `done`=0, `result`=0 and `overflow`=0.
- R2: In idle, `integ_clr` is 1. A `start` sampled high at a clock edge moves the block into the input phase, so `integ_clr` and `ref_sel` are both 0 from that edge on.
- R3: The input phase lasts exactly 2^CNT_W clock cycles. `ref_sel` rises at the 2^CNT_W-th edge after the start edge and stays 1 until the conversion ends.
- R4: The phase counter wraps to zero at the edge where `ref_sel` rises, so the reference-phase count starts from zero. With a zero input the result is 0.
- R5: `cmp_above` is delayed by SYNC_STAGES flops (default 2) before it is used. In the reference phase the counter advances by one on each clock while the synchronised comparator is 1.
- R6: When the synchronised comparator is 0 during the reference phase, the current count is latched into `result` and `done` is 1 for exactly one cycle. At that same edge the block returns to idle (`ref_sel`=0, `integ_clr`=1).
- R7: `result` and `overflow` change only at the edge where `done` goes high, and otherwise keep their value across the following conversion.
- R8: If the synchronised comparator is still 1 when the reference-phase count is all ones, the next edge ends the conversion. At that edge `result` becomes all ones, `overflow` becomes 1 and `done` pulses.
- R9: A conversion that ends normally clears `overflow` to 0.
- R10: `start` has no effect while a conversion is in progress, in either phase.
- R11: With an integrator that gains Vin per clock in the input phase and loses Vref per clock in the reference phase, the result equals ceil(2^CNT_W·Vin/Vref) plus the synchroniser latency, within two counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, acted on only in idle |
| cmp_above | input | 1 | Asynchronous comparator bit, 1 while the integrator has not returned to zero |
| ref_sel | output | 1 | Switch select: 0 routes the unknown input, 1 routes the negative reference |
| integ_clr | output | 1 | Integrator clear request, high while idle |
| result | output | CNT_W | Latched conversion count |
| overflow | output | 1 | Set when the last conversion timed out and saturated |
| done | output | 1 | One-cycle strobe when `result` is updated |

## Verification
The bench aims at the count boundaries. The input-phase length is checked against 2^CNT_W, and a miscounted wrap would shift `ref_sel` by a cycle and scale every result wrongly. An input of 99 out of 100 ends the reference phase on the last legal count. Inputs at and above the reference must saturate, so a design with an off-by-one timeout would either wrap to a small value or report 255 without the overflow flag. A zero input must return 0, which a design that fails to clear the counter would not. Start pulses in both phases catch a design that restarts mid-conversion, and the per-clock model comparison exposes a synchroniser with the wrong depth as results shifted by one count.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_INT   = 2'd1,
      PH_DEINT = 2'd2
   } phase_e;
endpackage

// File: rtl/dslope_sync.sv
// Multi-flop synchroniser for the asynchronous comparator bit.
module dslope_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh <= '0;
      end else begin
         sh[0] <= d;
         for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
      end
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/dslope_cnt.sv
// Phase counter: synchronous clear and enable, natural wrap at all ones.
module dslope_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt,
   output logic         full
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end

   assign full = &cnt;
endmodule

// File: rtl/dslope_ctrl.sv
// Phase sequencer and output latch.
module dslope_ctrl
   import dslope_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         cmp_s,
   input  logic [W-1:0] cnt,
   input  logic         full,
   output logic         cnt_clr,
   output logic         cnt_inc,
   output logic         ref_sel,
   output logic         integ_clr,
   output logic [W-1:0] result,
   output logic         overflow,
   output logic         done
);
   localparam logic [W-1:0] SAT = '1;

   phase_e ph;

   // counting continues only in the input phase or while the integrator is beyond zero
   always_comb begin
      cnt_clr = (ph == PH_IDLE) && start;
      cnt_inc = (ph == PH_INT) || ((ph == PH_DEINT) && cmp_s && !full);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         result   <= '0;
         overflow <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (ph)
            PH_IDLE: begin
               if (start) ph <= PH_INT;
            end
            PH_INT: begin
               // counter wraps to zero at this same edge
               if (full) ph <= PH_DEINT;
            end
            PH_DEINT: begin
               if (!cmp_s) begin
                  result   <= cnt;
                  overflow <= 1'b0;
                  done     <= 1'b1;
                  ph       <= PH_IDLE;
               end else if (full) begin
                  result   <= SAT;
                  overflow <= 1'b1;
                  done     <= 1'b1;
                  ph       <= PH_IDLE;
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign ref_sel   = (ph == PH_DEINT);
   assign integ_clr = (ph == PH_IDLE);
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq #(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cmp_above,
   output logic             ref_sel,
   output logic             integ_clr,
   output logic [CNT_W-1:0] result,
   output logic             overflow,
   output logic             done
);
   generate
      if (CNT_W < 2 || CNT_W > 24) begin : g_bad_width
         $error("dslope_seq: CNT_W must be within 2..24");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dslope_seq: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             cmp_s;
   logic [CNT_W-1:0] cnt;
   logic             full;
   logic             cnt_clr;
   logic             cnt_inc;

   dslope_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cmp_above),
      .q     (cmp_s)
   );

   dslope_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc),
      .cnt   (cnt),
      .full  (full)
   );

   dslope_ctrl #(.W(CNT_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cmp_s     (cmp_s),
      .cnt       (cnt),
      .full      (full),
      .cnt_clr   (cnt_clr),
      .cnt_inc   (cnt_inc),
      .ref_sel   (ref_sel),
      .integ_clr (integ_clr),
      .result    (result),
      .overflow  (overflow),
      .done      (done)
   );
endmodule

// File: rtl/dslope_chk.sv
module dslope_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ref_sel,
   input logic             integ_clr,
   input logic [CNT_W-1:0] result,
   input logic             overflow,
   input logic             done
);
   // cycles spent in the input phase of the current conversion
   logic [CNT_W:0] p1_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        p1_len <= '0;
      else if (integ_clr) p1_len <= '0;
      else if (!ref_sel)  p1_len <= p1_len + 1'b1;
   end

   a_r3_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_sel) |-> p1_len == {1'b1, {CNT_W{1'b0}}});

   a_r3_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ref_sel) |-> done);

   a_r2_starts_on_input: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(integ_clr) |-> !ref_sel);

   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (integ_clr && !ref_sel));

   a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(result) && $stable(overflow)));

   a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> (&result));
endmodule

bind dslope_seq dslope_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ref_sel   (ref_sel),
   .integ_clr (integ_clr),
   .result    (result),
   .overflow  (overflow),
   .done      (done)
);

// File: tb/sim_dslope_seq.sv
`timescale 1ns/1ps
module sim_dslope_seq;
   localparam int W   = 8;
   localparam int MAX = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         cmp_above = 1'b0;
   logic         ref_sel, integ_clr, overflow, done;
   logic [W-1:0] result;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   dslope_seq #(.CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .cmp_above(cmp_above),
      .ref_sel(ref_sel), .integ_clr(integ_clr), .result(result),
      .overflow(overflow), .done(done)
   );

   // behavioural integrator and comparator
   int vin  = 0;
   int vref = 100;
   int v    = 0;
   always @(negedge clk) begin
      if (integ_clr)     v = 0;
      else if (!ref_sel) v = v + vin;
      else               v = v - vref;
      cmp_above = (v > 0);
   end

   // cycle reference model
   int m_ph, m_cnt, m_res;
   bit m_ov, m_done;
   bit m_q[$];
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_res = 0; m_ov = 0; m_done = 0;
         m_q = '{0, 0};
      end else begin
         m_done = 0;
         if (m_ph == 0) begin
            if (start) begin m_ph = 1; m_cnt = 0; end
         end else if (m_ph == 1) begin
            if (m_cnt == MAX) begin m_ph = 2; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
         end else begin
            if (!m_q[0]) begin
               m_res = m_cnt; m_ov = 0; m_done = 1; m_ph = 0;
            end else if (m_cnt == MAX) begin
               m_res = MAX; m_ov = 1; m_done = 1; m_ph = 0;
            end else m_cnt = m_cnt + 1;
         end
         void'(m_q.pop_front());
         m_q.push_back(cmp_above);
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   bit run_cmp = 0;
   always @(negedge clk) begin
      if (run_cmp && rst_n) begin
         check("R3 ref_sel vs model", int'(ref_sel), int'(m_ph == 2));
         check("R2 integ_clr vs model", int'(integ_clr), int'(m_ph == 0));
         check("R6 done vs model", int'(done), int'(m_done));
         check("R5 result vs model", int'(result), m_res);
         check("R9 overflow vs model", int'(overflow), int'(m_ov));
      end
   end

   task automatic convert(input int vi, input int poke_at);
      int first_ref;
      bit seen;
      int k0;
      int held;
      vin = vi;
      first_ref = -1;
      seen = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int c = 0; c < 700; c++) begin
         if (c == poke_at + 1) check("R10 start while busy ignored", int'(integ_clr), 0);
         if (ref_sel && first_ref < 0) first_ref = c;
         if (done) begin seen = 1; break; end
         @(negedge clk);
         start = (c + 1 == poke_at);
      end
      start = 1'b0;
      check("R6 done seen", int'(seen), 1);
      check("R3 input phase length", first_ref, 1 << W);
      k0 = ((vi << W) + vref - 1) / vref;
      if (k0 >= MAX) begin
         check("R8 overflow flag", int'(overflow), 1);
         check("R8 saturated result", int'(result), MAX);
      end else begin
         check("R9 overflow clear", int'(overflow), 0);
         check("R11 result in range", int'(int'(result) >= k0 && int'(result) <= k0 + 2), 1);
         if (vi == 0) check("R4 counter cleared at phase change", int'(result), 0);
      end
      held = int'(result);
      repeat (4) @(negedge clk);
      check("R7 result held", int'(result), held);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset ref_sel", int'(ref_sel), 0);
      check("R1 reset integ_clr", int'(integ_clr), 1);
      check("R1 reset done", int'(done), 0);
      check("R1 reset result", int'(result), 0);
      check("R1 reset overflow", int'(overflow), 0);
      rst_n = 1'b1;
      run_cmp = 1'b1;
      @(negedge clk);
      check("R1 after reset integ_clr", int'(integ_clr), 1);
      convert(50, -1);
      convert(0, 10);
      convert(1, -1);
      convert(99, 300);
      convert(100, -1);
      convert(200, 20);
      convert(25, 270);
      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule